// File: doc/BRIEF.md
# Shuffle-Exchange Interconnect Stage

This block routes a vector of N = 2^ADDR_W data words through an iterated shuffle-exchange permutation. A word vector is captured on a start pulse. On each following clock one pass is applied in place: a perfect shuffle, then a row of conditional pair swaps. The shuffle moves the word at port address a to the address given by rotating a one bit to the left. The swap row then exchanges, under one control bit per pair, the two ports that differ only in their lowest address bit.

The caller supplies the number of passes with the start pulse. It also drives a fresh pair-control vector for every pass, which lets a sequence of passes build a routing. Deriving those control vectors from a target permutation is left to the caller. A one-cycle done pulse marks the point at which the routed vector is valid at the output. The output then holds that vector until the next start.

Top module: `shex_net`

## Requirements
- R1: After reset, data_o is all zeros and busy_o and done_o are low.
- R2: A start_i pulse while busy_o is low captures data_i and passes_i on that edge. With passes_i equal to 0, done_o is high in the following cycle and data_o equals the captured vector.
- R3: In each pass the word at port address a (word a occupies data bits a*DATA_W upward) moves to the address whose bits are a rotated left by one; with 3 address bits, b2b1b0 goes to b1b0b2.
- R4: After the shuffle of a pass, bit j of xchg_i equal to 1 swaps the words at ports 2j and 2j+1, while bit j equal to 0 leaves them in place. xchg_i is sampled on the clock edge that performs the pass, so each pass uses its own control vector.
- R5: Exactly one pass is performed per clock edge following the capture edge. After P passes (P > 0), done_o is high for the one cycle following the P-th pass edge, and data_o then holds the routed vector.
- R6: ADDR_W passes with xchg_i all zero return the vector to its original order.
- R7: A start_i pulse while busy_o is high is ignored: neither the data nor the remaining pass count changes.
- R8: While busy_o is low and start_i is low, data_o holds its value even if data_i, passes_i or xchg_i change.
- R9: busy_o is high from the cycle after a capture with a nonzero count until the final pass edge, and busy_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture request |
| passes_i | input | PASS_W | Number of passes to apply |
| data_i | input | N*DATA_W | Input word vector, word a at bits a*DATA_W upward |
| xchg_i | input | N/2 | Pair swap controls for the current pass |
| data_o | output | N*DATA_W | Working / routed word vector |
| busy_o | output | 1 | Passes in progress |
| done_o | output | 1 | One-cycle pulse: routed vector valid |

## Verification
The capture is visible one edge after start_i. Each pass is visible one edge after the control vector it used was driven. The done pulse and the final vector therefore appear P edges after the capture edge. The bench drives every input on the falling edge. It sets the control vector for pass p in the half-cycle before that pass's rising edge, and samples busy_o, done_o and data_o on the falling edge after each rising edge. As a result, each observation falls a whole number of edges after the stimulus it depends on, and the expected vector is stepped by one model pass per edge.

// File: rtl/shex_pkg.sv
package shex_pkg;
   // rotate an address left by one within a width
   function automatic int unsigned rotl1(input int unsigned a, input int unsigned w);
      int unsigned msb;
      msb = (a >> (w - 1)) & 1;
      return ((a << 1) & ((1 << w) - 1)) | msb;
   endfunction

   // inverse: rotate right by one
   function automatic int unsigned rotr1(input int unsigned a, input int unsigned w);
      return (a >> 1) | ((a & 1) << (w - 1));
   endfunction
endpackage

// File: rtl/shex_shuffle.sv
module shex_shuffle #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   localparam int N     = 1 << ADDR_W
) (
   input  logic [N*DATA_W-1:0] vec_i,
   output logic [N*DATA_W-1:0] vec_o
);
   import shex_pkg::*;
   // destination d receives the word whose address rotates left onto d
   for (genvar d = 0; d < N; d++) begin : g_dst
      localparam int SRC = int'(rotr1(d, ADDR_W));
      assign vec_o[d*DATA_W +: DATA_W] = vec_i[SRC*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/shex_exchange.sv
module shex_exchange #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   localparam int N     = 1 << ADDR_W,
   localparam int PAIRS = N / 2
) (
   input  logic [N*DATA_W-1:0] vec_i,
   input  logic [PAIRS-1:0]    swap_i,
   output logic [N*DATA_W-1:0] vec_o
);
   for (genvar j = 0; j < PAIRS; j++) begin : g_pair
      localparam int LO = 2 * j;
      localparam int HI = 2 * j + 1;
      logic [DATA_W-1:0] w_lo, w_hi;
      assign w_lo = vec_i[LO*DATA_W +: DATA_W];
      assign w_hi = vec_i[HI*DATA_W +: DATA_W];
      assign vec_o[LO*DATA_W +: DATA_W] = swap_i[j] ? w_hi : w_lo;
      assign vec_o[HI*DATA_W +: DATA_W] = swap_i[j] ? w_lo : w_hi;
   end
endmodule

// File: rtl/shex_ctrl.sv
module shex_ctrl #(
   parameter int PASS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PASS_W-1:0] passes_i,
   output logic              load_o,
   output logic              step_o,
   output logic              busy_o,
   output logic              done_o
);
   logic [PASS_W-1:0] left_q;
   logic              busy_q, done_q;

   assign load_o = start_i & ~busy_q;
   assign step_o = busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (load_o) begin
         left_q <= passes_i;
         busy_q <= (passes_i != '0);
         done_q <= (passes_i == '0);
      end else if (busy_q) begin
         left_q <= left_q - 1'b1;
         busy_q <= (left_q != PASS_W'(1));
         done_q <= (left_q == PASS_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end
endmodule

// File: rtl/shex_net.sv
module shex_net #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int PASS_W = 4,
   localparam int N     = 1 << ADDR_W,
   localparam int PAIRS = N / 2,
   localparam int VW    = N * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PASS_W-1:0] passes_i,
   input  logic [VW-1:0]     data_i,
   input  logic [PAIRS-1:0]  xchg_i,
   output logic [VW-1:0]     data_o,
   output logic              busy_o,
   output logic              done_o
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("shex_net: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("shex_net: DATA_W must be positive");
   end
   if (PASS_W < 1) begin : g_bad_pass
      $error("shex_net: PASS_W must be positive");
   end

   logic [VW-1:0] vec_q, shuf_w, exch_w;
   logic          load_w, step_w;

   shex_ctrl #(.PASS_W(PASS_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .passes_i (passes_i),
      .load_o   (load_w),
      .step_o   (step_w),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

   shex_shuffle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shuf_i (
      .vec_i (vec_q),
      .vec_o (shuf_w)
   );

   shex_exchange #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) exch_i (
      .vec_i  (shuf_w),
      .swap_i (xchg_i),
      .vec_o  (exch_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vec_q <= '0;
      else if (load_w) vec_q <= data_i;
      else if (step_w) vec_q <= exch_w;
   end

   assign data_o = vec_q;
endmodule

// File: rtl/shex_net_chk.sv
module shex_net_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int PASS_W = 4,
   localparam int N     = 1 << ADDR_W,
   localparam int VW    = N * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [PASS_W-1:0] passes_i,
   input logic [VW-1:0]     data_i,
   input logic [VW-1:0]     data_o,
   input logic              busy_o,
   input logic              done_o
);
   logic [DATA_W-1:0] fold_w;
   always_comb begin
      fold_w = '0;
      for (int a = 0; a < N; a++) fold_w ^= data_o[a*DATA_W +: DATA_W];
   end

   // R9
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   // R2
   zero_pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && passes_i == '0) |=> (done_o && data_o == $past(data_i)));

   // R9
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && passes_i != '0) |=> (busy_o && data_o == $past(data_i)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(data_o));

   // R3
   perm_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (fold_w == $past(fold_w)));
endmodule

bind shex_net shex_net_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .passes_i (passes_i),
   .data_i   (data_i),
   .data_o   (data_o),
   .busy_o   (busy_o),
   .done_o   (done_o)
);

// File: tb/shex_net_tb_top.sv
module shex_net_tb_top;
   localparam int AW = 3;
   localparam int W  = 8;
   localparam int PW = 4;
   localparam int N  = 1 << AW;
   localparam int NP = N / 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [PW-1:0]   passes_i = '0;
   logic [N*W-1:0]  data_i = '0;
   logic [NP-1:0]   xchg_i = '0;
   logic [N*W-1:0]  data_o;
   logic            busy_o, done_o;

   int errors = 0;
   int checks = 0;

   logic [W-1:0]    vin [N];
   logic [W-1:0]    mdl [N];
   logic [NP-1:0]   ctl [16];
   logic [15:0]     lfsr = 16'hACE1;

   always #2 clk = ~clk;

   shex_net #(.ADDR_W(AW), .DATA_W(W), .PASS_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .passes_i(passes_i),
      .data_i(data_i), .xchg_i(xchg_i), .data_o(data_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [N*W-1:0] pack_mdl();
      logic [N*W-1:0] v;
      for (int a = 0; a < N; a++) v[a*W +: W] = mdl[a];
      return v;
   endfunction

   function automatic logic [N*W-1:0] pack_vin();
      logic [N*W-1:0] v;
      for (int a = 0; a < N; a++) v[a*W +: W] = vin[a];
      return v;
   endfunction

   // one model pass: rotate-left shuffle, then pair swaps
   task automatic model_pass(input logic [NP-1:0] c);
      logic [W-1:0] t [N];
      logic [W-1:0] s;
      for (int a = 0; a < N; a++) t[((a << 1) & (N - 1)) | (a >> (AW - 1))] = mdl[a];
      for (int j = 0; j < NP; j++) begin
         if (c[j]) begin
            s = t[2*j]; t[2*j] = t[2*j+1]; t[2*j+1] = s;
         end
      end
      for (int a = 0; a < N; a++) mdl[a] = t[a];
   endtask

   task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // np passes using ctl[0..np-1]; poke issues a start while busy
   task automatic run(input int np, input bit poke, input string req);
      @(negedge clk);
      start_i = 1'b1; data_i = pack_vin(); passes_i = PW'(np);
      for (int a = 0; a < N; a++) mdl[a] = vin[a];
      @(negedge clk);
      start_i = 1'b0;
      for (int p = 0; p < np; p++) begin
         chk("R9", {busy_o, done_o}, 2'b10);
         xchg_i = ctl[p];
         if (poke && p == 0) begin
            start_i = 1'b1; data_i = ~pack_vin(); passes_i = PW'(1);
         end
         model_pass(ctl[p]);
         @(negedge clk);
         start_i = 1'b0;
      end
      chk("R5", {busy_o, done_o}, 2'b01);
      chk(req, data_o, pack_mdl());
      @(negedge clk);
      chk("R5", done_o, 1'b0);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int a = 0; a < N; a++) vin[a] = W'(8'h10 + a);
      for (int p = 0; p < 16; p++) ctl[p] = '0;
      #1;
      chk("R1", {data_o, busy_o, done_o}, '0);
      #9 rst_n = 1'b1;

      // R2: zero passes
      run(0, 0, "R2");

      // R3: single and double passes, no swaps
      run(1, 0, "R3");
      run(2, 0, "R3");
      // R6: ADDR_W passes without swaps gives identity
      run(AW, 0, "R6");
      chk("R6", data_o, pack_vin());

      // R4: every control value on a single pass
      for (int c = 0; c < (1 << NP); c++) begin
         ctl[0] = NP'(c);
         run(1, 0, "R4");
      end

      // R4/R5: varied controls per pass, varied counts
      for (int r = 0; r < 24; r++) begin
         for (int a = 0; a < N; a++) begin step_lfsr(); vin[a] = lfsr[W-1:0]; end
         for (int p = 0; p < 16; p++) begin step_lfsr(); ctl[p] = lfsr[NP-1:0]; end
         run(1 + (r % 9), 0, "R5");
      end

      // R7: start while busy ignored
      for (int p = 0; p < 16; p++) ctl[p] = NP'(p + 3);
      run(5, 1, "R7");

      // R8: idle hold against input changes
      begin
         logic [N*W-1:0] held;
         held = data_o;
         data_i = ~held; passes_i = '1; xchg_i = '1;
         repeat (3) @(negedge clk);
         chk("R8", data_o, held);
         chk("R8", {busy_o, done_o}, 2'b00);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule